// File: doc/BRIEF.md
# Temporal Majority Sampling Corrector

This block sits at the output of a combinational logic cloud of known depth and removes transient, noise-induced bit errors without duplicating that logic. When new operands are applied, the surrounding system pulses `start_i` and then keeps the operands steady. From then on, each pulse of `step_i` marks the end of one gate-delay step. The logic output is allowed to settle for `DEPTH` steps. The block then captures the output bus once per step, over `SAMPLES` consecutive steps, and forms a per-bit majority over those time samples.

Every output bit has its own sample history and its own voter. When the last sample arrives, the voted word is registered on `vote_o` and `done_o` pulses for one clock. A `start_i` that arrives while a sampling window is open is rejected, and `overlap_o` reports it. The caller must hold the logic inputs steady from the start pulse until `done_o`. The block depends on that hold and does not check it.

Top module: `tms_corrector`

## Requirements
- R1: `SAMPLES` is an odd parameter of at least 3. The block works with both 3 samples (2-of-3 vote) and 7 samples (4-of-7 vote).
- R2: A `start_i` pulse while idle opens a window. Step strobes are numbered 1, 2, 3, ... starting with the first `step_i` cycle after the start cycle.
- R3: The bus `logic_i` is captured only on strobes `DEPTH` through `DEPTH+SAMPLES-1`. Its value at any other time has no effect on the result.
- R4: Each bit of `vote_o` depends only on the samples of the same bit position of `logic_i`.
- R5: A bit of the voted word is 1 exactly when at least (`SAMPLES`+1)/2 of its samples are 1, and 0 otherwise.
- R6: `vote_o` takes the new result and `done_o` goes high on the clock edge that captures strobe `DEPTH+SAMPLES-1`. At all other times `vote_o` keeps its value.
- R7: `done_o` is high for exactly one clock per window.
- R8: A `start_i` while a window is open is ignored, so the running window completes with an unchanged result. `overlap_o` is 1 for the single cycle after that start. A start while idle leaves `overlap_o` at 0.
- R9: Synchronous reset `rst` clears the sample histories, the step counter, `vote_o`, `done_o` and `overlap_o`, and it abandons any open window.
- R10: `step_i` strobes while no window is open change neither `vote_o` nor `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Pulse: new operands applied to the protected logic |
| step_i | input | 1 | Pulse: end of one gate-delay step |
| logic_i | input | WIDTH | Output bus of the protected logic |
| vote_o | output | WIDTH | Majority-corrected word |
| done_o | output | 1 | One-cycle pulse when `vote_o` is updated |
| overlap_o | output | 1 | One-cycle pulse after a rejected start |

## Verification
Two directed patterns, all-zero and all-one samples, show that the vote does not lean towards either value. A staircase pattern gives bit b exactly b mod (SAMPLES+1) ones, so one window places some bits just below and some just above the threshold, for both 3 and 7 samples. Random words drive `logic_i` before the window and between strobes, which shows that only the windowed strobes are captured. Random windows with random gaps between strobes, a start injected mid-window, strobes while idle, and a reset inside a window separate correct counting and rejection from off-by-one window placement.

// File: rtl/tms_pkg.sv
`timescale 1ns/1ps
package tms_pkg;

    // Control decoded from the step counter for the current cycle.
    typedef struct packed {
        logic capture;   // sample logic_i on this cycle
        logic last;      // this capture completes the window
    } win_ctl_t;

    // Minimum number of ones that forms a strict majority of n samples.
    function automatic int maj_threshold(input int n);
        return (n + 1) / 2;
    endfunction

    // Width of a counter that must represent the value n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tms_window.sv
`timescale 1ns/1ps
module tms_window
    import tms_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int SAMPLES = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     step_i,
    output win_ctl_t ctl_o,
    output logic     busy_o,
    output logic     overlap_o
);
    localparam int CW = cnt_width(DEPTH + SAMPLES);
    localparam logic [CW-1:0] FIRST_STROBE = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_STROBE  = CW'(DEPTH + SAMPLES - 1);

    logic [CW-1:0] count_q;
    logic [CW-1:0] count_nxt;
    logic          busy_q;
    logic          overlap_q;

    assign count_nxt = count_q + CW'(1);

    always_comb begin
        ctl_o         = '0;
        ctl_o.capture = busy_q && step_i &&
                        (count_nxt >= FIRST_STROBE) && (count_nxt <= LAST_STROBE);
        ctl_o.last    = ctl_o.capture && (count_nxt == LAST_STROBE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            busy_q    <= 1'b0;
            overlap_q <= 1'b0;
        end else begin
            overlap_q <= start_i && busy_q;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q  <= 1'b1;
                    count_q <= '0;
                end
            end else if (step_i) begin
                count_q <= count_nxt;
                if (ctl_o.last) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy_o    = busy_q;
    assign overlap_o = overlap_q;

endmodule

// File: rtl/tms_sampler.sv
`timescale 1ns/1ps
module tms_sampler #(
    parameter int WIDTH   = 8,
    parameter int SAMPLES = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            shift_i,
    input  logic [WIDTH-1:0]                data_i,
    output logic [WIDTH-1:0][SAMPLES-1:0]   nxt_o
);
    logic [WIDTH-1:0][SAMPLES-1:0] hist_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign nxt_o[b] = {hist_q[b][SAMPLES-2:0], data_i[b]};

        always_ff @(posedge clk) begin
            if (rst) begin
                hist_q[b] <= '0;
            end else if (shift_i) begin
                hist_q[b] <= nxt_o[b];
            end
        end
    end

endmodule

// File: rtl/tms_voter.sv
`timescale 1ns/1ps
module tms_voter
    import tms_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int SAMPLES = 3
) (
    input  logic [WIDTH-1:0][SAMPLES-1:0] hist_i,
    output logic [WIDTH-1:0]              maj_o
);
    localparam int NW  = cnt_width(SAMPLES);
    localparam int THR = maj_threshold(SAMPLES);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [NW-1:0] ones;

        always_comb begin
            ones = '0;
            for (int j = 0; j < SAMPLES; j++) begin
                ones = ones + NW'(hist_i[b][j]);
            end
        end

        assign maj_o[b] = (ones >= NW'(THR));
    end

endmodule

// File: rtl/tms_corrector.sv
`timescale 1ns/1ps
module tms_corrector
    import tms_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int DEPTH   = 4,
    parameter int SAMPLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] logic_i,
    output logic [WIDTH-1:0] vote_o,
    output logic             done_o,
    output logic             overlap_o
);
    // R1: sample count must be odd and at least three
    initial begin
        a_r1_sample_count: assert (SAMPLES >= 3 && (SAMPLES % 2) == 1);
    end

    win_ctl_t                      ctl;
    logic                          busy;
    logic [WIDTH-1:0][SAMPLES-1:0] hist_nxt;
    logic [WIDTH-1:0]              maj;
    logic [WIDTH-1:0]              vote_q;
    logic                          done_q;

    tms_window #(.DEPTH(DEPTH), .SAMPLES(SAMPLES)) u_win (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .step_i    (step_i),
        .ctl_o     (ctl),
        .busy_o    (busy),
        .overlap_o (overlap_o)
    );

    tms_sampler #(.WIDTH(WIDTH), .SAMPLES(SAMPLES)) u_smp (
        .clk     (clk),
        .rst     (rst),
        .shift_i (ctl.capture),
        .data_i  (logic_i),
        .nxt_o   (hist_nxt)
    );

    tms_voter #(.WIDTH(WIDTH), .SAMPLES(SAMPLES)) u_vote (
        .hist_i (hist_nxt),
        .maj_o  (maj)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vote_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= ctl.last;
            if (ctl.last) begin
                vote_q <= maj;
            end
        end
    end

    assign vote_o = vote_q;
    assign done_o = done_q;

endmodule

// File: rtl/tms_corrector_chk.sv
`timescale 1ns/1ps
module tms_corrector_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             step_i,
    input logic             busy,
    input logic [WIDTH-1:0] vote_o,
    input logic             done_o,
    input logic             overlap_o
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    // R7: the completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: completion only follows a strobe inside an open window
    a_r6_done_after_strobe: assert property (@(posedge clk) disable iff (rst || !past_ok)
        done_o |-> ($past(busy) && $past(step_i)));

    // R6: the result holds between completions
    a_r6_vote_holds: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !done_o |-> $stable(vote_o));

    // R8: a rejection is reported only after a start during an open window
    a_r8_overlap_cause: assert property (@(posedge clk) disable iff (rst || !past_ok)
        overlap_o |-> $past(start_i && busy));

    // R8: a start while a window is open does not end it
    a_r8_window_kept: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy && !step_i) |=> busy);

    // R9: reset clears the outputs
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!done_o && !overlap_o && vote_o == '0 && !busy));

endmodule

bind tms_corrector tms_corrector_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tms_corrector_test.sv
`timescale 1ns/1ps
module tms_corrector_test;
    localparam int W = 8;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_a = 1'b0, step_a = 1'b0, start_b = 1'b0, step_b = 1'b0;
    logic [W-1:0] bus = '0;
    logic [W-1:0] vote_a, vote_b;
    logic done_a, done_b, ovl_a, ovl_b;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    tms_corrector #(.WIDTH(W), .DEPTH(D), .SAMPLES(3)) uut (
        .clk(clk), .rst(rst), .start_i(start_a), .step_i(step_a), .logic_i(bus),
        .vote_o(vote_a), .done_o(done_a), .overlap_o(ovl_a));

    tms_corrector #(.WIDTH(W), .DEPTH(D), .SAMPLES(7)) uut7 (
        .clk(clk), .rst(rst), .start_i(start_b), .step_i(step_b), .logic_i(bus),
        .vote_o(vote_b), .done_o(done_b), .overlap_o(ovl_b));

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_vote(input int n, input logic [W-1:0] s [7]);
        logic [W-1:0] r = '0;
        for (int b = 0; b < W; b++) begin
            int ones = 0;
            for (int j = 0; j < n; j++) ones += int'(s[j][b]);
            r[b] = (ones >= (n + 1) / 2);
        end
        return r;
    endfunction

    function automatic logic get_done(input bit sel);
        return sel ? done_b : done_a;
    endfunction
    function automatic logic get_ovl(input bit sel);
        return sel ? ovl_b : ovl_a;
    endfunction
    function automatic logic [W-1:0] get_vote(input bit sel);
        return sel ? vote_b : vote_a;
    endfunction

    task automatic set_start(input bit sel, input logic v);
        if (sel) start_b = v; else start_a = v;
    endtask
    task automatic set_step(input bit sel, input logic v);
        if (sel) step_b = v; else step_a = v;
    endtask

    // One full window; noise on the bus outside the capture strobes (R3).
    task automatic run_window(input bit sel, input logic [W-1:0] s [7],
                              input bit inject, input string tag);
        int n = sel ? 7 : 3;
        int total = D + n - 1;
        bit early = 0;
        logic [W-1:0] exp = exp_vote(n, s);
        @(negedge clk);
        set_start(sel, 1'b1);
        bus = W'($urandom);
        @(negedge clk);
        set_start(sel, 1'b0);
        check(get_ovl(sel) == 1'b0, "R8 idle start not flagged", get_ovl(sel), 0);
        for (int k = 1; k <= total; k++) begin
            int gap = $urandom % 3;
            repeat (gap) begin
                bus = W'($urandom);
                @(negedge clk);
                if (get_done(sel)) early = 1;
            end
            bus = (k >= D) ? s[k - D] : W'($urandom);
            set_step(sel, 1'b1);
            if (inject && k == 2) set_start(sel, 1'b1);
            @(negedge clk);
            set_step(sel, 1'b0);
            set_start(sel, 1'b0);
            if (inject && k == 2)
                check(get_ovl(sel) == 1'b1, "R8 overlap flagged", get_ovl(sel), 1);
            if (k < total && get_done(sel)) early = 1;
        end
        bus = W'($urandom);
        check(!early, {"R2 R3 no early done ", tag}, early, 0);
        check(get_done(sel) == 1'b1, {"R6 done at last strobe ", tag}, get_done(sel), 1);
        check(get_vote(sel) == exp, {"R5 R4 vote ", tag}, get_vote(sel), exp);
        @(negedge clk);
        check(get_done(sel) == 1'b0, {"R7 done one cycle ", tag}, get_done(sel), 0);
        check(get_vote(sel) == exp, {"R6 vote held ", tag}, get_vote(sel), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] s [7];
        logic [W-1:0] held;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R9: state after reset
        check(vote_a == '0 && vote_b == '0, "R9 reset vote", {vote_a, vote_b}, 0);
        check(!done_a && !done_b, "R9 reset done", {done_a, done_b}, 0);
        check(!ovl_a && !ovl_b, "R9 reset overlap", {ovl_a, ovl_b}, 0);

        for (int sel = 0; sel < 2; sel++) begin
            int n = sel ? 7 : 3;
            // R1 R5: all ones, all zeros, staircase across the threshold
            for (int j = 0; j < 7; j++) s[j] = '1;
            run_window(sel[0], s, 0, "ones");
            for (int j = 0; j < 7; j++) s[j] = '0;
            run_window(sel[0], s, 0, "zeros");
            for (int j = 0; j < 7; j++)
                for (int b = 0; b < W; b++) s[j][b] = (j < (b % (n + 1)));
            run_window(sel[0], s, 0, "staircase");
            for (int j = 0; j < 7; j++)
                for (int b = 0; b < W; b++) s[j][b] = (j >= n - (b % (n + 1)));
            run_window(sel[0], s, 0, "staircase-rev");
        end

        // R8: start inside an open window is ignored
        for (int j = 0; j < 7; j++) s[j] = W'($urandom);
        run_window(0, s, 1, "overlap3");
        run_window(1, s, 1, "overlap7");

        // R10: strobes while idle
        held = vote_a;
        repeat (3) begin
            @(negedge clk); step_a = 1'b1; bus = W'($urandom);
            @(negedge clk); step_a = 1'b0;
            check(done_a == 1'b0, "R10 idle strobe no done", done_a, 0);
        end
        check(vote_a == held, "R10 idle strobe vote kept", vote_a, held);

        // R9: reset inside an open window, then a clean window
        @(negedge clk); start_a = 1'b1;
        @(negedge clk); start_a = 1'b0; step_a = 1'b1;
        @(negedge clk); step_a = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(vote_a == '0 && !done_a, "R9 mid-window reset", vote_a, 0);
        for (int j = 0; j < 7; j++) s[j] = W'($urandom);
        run_window(0, s, 0, "after-reset");

        // R2 R3 R4 R5: random windows
        for (int t = 0; t < 15; t++) begin
            for (int j = 0; j < 7; j++) s[j] = W'($urandom);
            run_window(0, s, 0, "random3");
            run_window(1, s, 0, "random7");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule